// File: doc/BRIEF.md
# SD SPI-Mode Data Block Writer

This engine carries the data phase of a card write in SPI mode, once the write command has been issued elsewhere. For every block it sends a filler byte, a start token, the payload pulled from a byte stream, and a CRC16 that it builds as the bytes go by. It then reads back bytes until the card returns its data-response token, decodes the token, and polls the card until the busy period ends. A multi-block write uses its own start token. After the last block the engine sends a stop token and waits out one more busy period.

Every byte on the card side goes through a byte-exchange port. The engine offers a transmit byte with `bx_valid`. The exchange completes on a clock edge where `bx_ack` is also high, and `bx_rx` holds the byte received in that same exchange. When the transfer ends, the engine raises `done` for one cycle with a 2-bit status code: 0 success, 1 block rejected, 2 busy timeout.

Top module: `sdspi_wr_engine`

## Requirements
- R1: Each block begins with an exchange sending 0xFF, then an exchange sending the start token: 0xFE when `multi` is 0, 0xFC when `multi` is 1.
- R2: The payload takes exactly `blk_size` exchanges per block, sending the stream bytes in order. `pl_ready` is high only during payload exchanges, and only while `bx_ack` is high. A byte is consumed when `pl_valid` and `pl_ready` are both high.
- R3: The payload is followed by its CRC16, high byte first. The CRC uses polynomial 0x1021, a zero seed, and processes the bits of each byte most significant first.
- R4: After the CRC the engine sends 0xFF for up to 8 exchanges. The first received byte with bit 4 clear is taken as the response token. The block is accepted when the token's low 5 bits equal 0x05, whatever its upper 3 bits hold.
- R5: A token whose low 5 bits are anything other than 0x05 (for example 0x0B or 0x0D), or 8 reads that all have bit 4 set, ends the transfer right after that read with status 1.
- R6: After acceptance the engine polls by sending 0xFF. It ignores the byte from the first poll. The busy period ends at the first later poll that returns 0xFF.
- R7: If the busy period has not ended within BUSY_LIMIT polls, the transfer ends right after the last of those polls with status 2.
- R8: After the final block of a multi-block write, the engine sends 0xFF and then 0xFD, and applies the R6/R7 busy wait once more before finishing. A single-block write finishes directly after its busy wait.
- R9: A multi-block write that ends on a rejection or a timeout sends no stop token.
- R10: After reset, and whenever `busy` is low, no exchange is requested. `busy` rises on the cycle after an accepted `start`. `done` is a one-cycle pulse, with `busy` low and `err` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer; sampled while idle |
| multi | input | 1 | 1 selects a multi-block write |
| blk_count | input | CW | Number of blocks, must be non-zero |
| blk_size | input | SW | Payload bytes per block, must be non-zero |
| pl_data | input | 8 | Payload stream byte |
| pl_valid | input | 1 | Payload byte available |
| pl_ready | output | 1 | Payload byte taken this cycle when valid |
| bx_valid | output | 1 | Exchange requested |
| bx_tx | output | 8 | Byte to send |
| bx_ack | input | 1 | Exchange completes this cycle |
| bx_rx | input | 8 | Byte received in the completing exchange |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 2 | Status with done: 0 ok, 1 rejected, 2 busy timeout |

## Verification
A wrong state or counter in this engine shows up at the next completed exchange: a misplaced state or a wrong payload counter sends a byte that differs from the expected frame. A corrupted CRC register shows up on the two CRC exchanges of the same block. A miscounted response window or busy poll counter changes the number of exchanges before `done`, so the next exchange the card offers, or the done check, reports the error within a few cycles. Sweeps over payload size, block count, token position, busy length and the two timeout edges cover every path between states.

// File: rtl/sdspi_wr_engine.sv
module sdspi_wr_engine #(
  parameter int CW = 16,
  parameter int SW = 10,
  parameter int BUSY_LIMIT = 3000000,
  parameter int RESP_TRIES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          multi,
  input  logic [CW-1:0] blk_count,
  input  logic [SW-1:0] blk_size,
  input  logic [7:0]    pl_data,
  input  logic          pl_valid,
  output logic          pl_ready,
  output logic          bx_valid,
  output logic [7:0]    bx_tx,
  input  logic          bx_ack,
  input  logic [7:0]    bx_rx,
  output logic          busy,
  output logic          done,
  output logic [1:0]    err
);
  localparam int PMAX = (BUSY_LIMIT > RESP_TRIES) ? BUSY_LIMIT : RESP_TRIES;
  localparam int PW = $clog2(PMAX + 1);
  localparam logic [1:0] E_OK = 2'd0, E_REJ = 2'd1, E_TMO = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_TOK, S_DATA, S_CRCH, S_CRCL, S_RESP, S_BUSY, S_SGAP, S_STOK
  } st_t;

  st_t st;
  logic          multi_q, stopping;
  logic [CW-1:0] left;
  logic [SW-1:0] size_q, cnt;
  logic [15:0]   crc;
  logic [PW-1:0] poll;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++)
      r = r[15] ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
    return r;
  endfunction

  wire fire = bx_valid & bx_ack;
  assign busy     = (st != S_IDLE);
  assign bx_valid = (st == S_DATA) ? pl_valid : busy;
  assign pl_ready = (st == S_DATA) & bx_ack;

  always_comb begin
    case (st)
      S_TOK:   bx_tx = multi_q ? 8'hFC : 8'hFE;
      S_DATA:  bx_tx = pl_data;
      S_CRCH:  bx_tx = crc[15:8];
      S_CRCL:  bx_tx = crc[7:0];
      S_STOK:  bx_tx = 8'hFD;
      default: bx_tx = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; multi_q <= 1'b0; stopping <= 1'b0; left <= '0;
      size_q <= '0; cnt <= '0; crc <= '0; poll <= '0; done <= 1'b0; err <= E_OK;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          multi_q <= multi; left <= blk_count; size_q <= blk_size;
          stopping <= 1'b0; err <= E_OK; st <= S_GAP;
        end
        S_GAP: if (fire) st <= S_TOK;
        S_TOK: if (fire) begin st <= S_DATA; cnt <= '0; crc <= '0; end
        S_DATA: if (fire) begin
          crc <= crc_step(crc, pl_data);
          cnt <= cnt + 1'b1;
          if (cnt == SW'(size_q - 1'b1)) st <= S_CRCH;
        end
        S_CRCH: if (fire) st <= S_CRCL;
        S_CRCL: if (fire) begin st <= S_RESP; poll <= '0; end
        S_RESP: if (fire) begin
          poll <= poll + 1'b1;
          if (!bx_rx[4] || poll == PW'(RESP_TRIES - 1)) begin
            if (bx_rx[4:0] == 5'h05) begin
              st <= S_BUSY; poll <= '0;
            end else begin
              st <= S_IDLE; done <= 1'b1; err <= E_REJ;
            end
          end
        end
        S_BUSY: if (fire) begin
          poll <= poll + 1'b1;
          if (poll != '0 && bx_rx == 8'hFF) begin
            if (stopping) begin
              st <= S_IDLE; done <= 1'b1;
            end else if (left == CW'(1)) begin
              if (multi_q) st <= S_SGAP;
              else begin st <= S_IDLE; done <= 1'b1; end
            end else begin
              left <= left - 1'b1; st <= S_GAP;
            end
          end else if (poll == PW'(BUSY_LIMIT - 1)) begin
            st <= S_IDLE; done <= 1'b1; err <= E_TMO;
          end
        end
        S_SGAP: if (fire) st <= S_STOK;
        S_STOK: if (fire) begin st <= S_BUSY; poll <= '0; stopping <= 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bx_valid && !pl_ready));
  p_ready_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> (bx_ack && st == S_DATA));
  p_resp_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RESP) |-> (poll < PW'(RESP_TRIES)));
  p_busy_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY) |-> (poll < PW'(BUSY_LIMIT)));
  p_hold_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bx_valid && !bx_ack && st != S_DATA) |=> (bx_valid && $stable(bx_tx)));
endmodule

// File: tb/sdspi_wr_engine_test.sv
module sdspi_wr_engine_test;
  localparam int CW = 3, SW = 4, LIM = 12;
  localparam logic [1:0] E_OK = 2'd0, E_REJ = 2'd1, E_TMO = 2'd2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, multi, pl_valid, pl_ready, bx_valid, bx_ack, busy, done;
  logic [CW-1:0] blk_count;
  logic [SW-1:0] blk_size;
  logic [7:0] pl_data, bx_tx, bx_rx;
  logic [1:0] err;
  int nvec = 0, nbad = 0, sc = 0;

  sdspi_wr_engine #(.CW(CW), .SW(SW), .BUSY_LIMIT(LIM), .RESP_TRIES(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .multi(multi), .blk_count(blk_count),
    .blk_size(blk_size), .pl_data(pl_data), .pl_valid(pl_valid), .pl_ready(pl_ready),
    .bx_valid(bx_valid), .bx_tx(bx_tx), .bx_ack(bx_ack), .bx_rx(bx_rx),
    .busy(busy), .done(done), .err(err));

  function automatic logic [15:0] crc_bits(input logic [15:0] c, input logic [7:0] d);
    logic fb;
    for (int k = 7; k >= 0; k--) begin
      fb = c[15] ^ d[k];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [7:0] pat(input int b, input int i);
    return 8'((b * 29 + i * 7 + 60) % 256);
  endfunction

  task automatic xchg(input logic [7:0] etx, input logic [7:0] rx, input logic is_pl, input string req);
    int m = sc % 3;
    sc++;
    if (m != 0) begin
      @(negedge clk);
      bx_ack = (m == 2) && is_pl; pl_valid = is_pl && (m == 1);
      pl_data = etx; bx_rx = 8'h00;
      @(posedge clk);
    end
    @(negedge clk);
    bx_ack = 1'b1; pl_valid = is_pl; pl_data = etx; bx_rx = rx;
    #1;
    nvec++;
    if (!(bx_valid && bx_tx == etx && pl_ready == is_pl)) begin
      nbad++;
      $display("FAIL %s: valid=%0b tx=%02h ready=%0b expected valid=1 tx=%02h ready=%0b",
               req, bx_valid, bx_tx, pl_ready, etx, is_pl);
    end
    @(posedge clk);
    #1 bx_ack = 1'b0; pl_valid = 1'b0;
  endtask

  task automatic check_done(input logic [1:0] eerr, input string req);
    @(negedge clk);
    nvec++;
    if (!(done && err == eerr && !busy)) begin
      nbad++;
      $display("FAIL %s: done=%0b err=%0d busy=%0b expected done=1 err=%0d busy=0",
               req, done, err, busy, eerr);
    end
    @(negedge clk);
    nvec++;
    if (done || busy || bx_valid) begin
      nbad++;
      $display("FAIL R10: done=%0b busy=%0b valid=%0b expected 0 0 0", done, busy, bx_valid);
    end
  endtask

  task automatic launch(input logic m, input int nb, input int sz);
    @(negedge clk);
    start = 1'b1; multi = m; blk_count = CW'(nb); blk_size = SW'(sz);
    @(posedge clk);
    #1 start = 1'b0;
    nvec++;
    if (!busy) begin
      nbad++;
      $display("FAIL R10: busy=%0b expected 1 after start", busy);
    end
  endtask

  task automatic busy_phase(input int bsy, input string req, output logic tmo);
    int n = (bsy == 0) ? 2 : bsy + 1;
    tmo = (n > LIM);
    if (tmo) n = LIM;
    for (int k = 0; k < n; k++)
      xchg(8'hFF, (k == 0) ? ((bsy == 0) ? 8'hFF : 8'h00) : ((k >= bsy) ? 8'hFF : 8'h00), 1'b0, req);
  endtask

  task automatic run(input logic m, input int nb, input int sz, input int rdel, input int bad_blk,
                     input logic [7:0] bad_tok, input int bsy, input int sbsy, input logic [1:0] eerr);
    logic [15:0] crc;
    logic tmo;
    string abort_tag;
    abort_tag = m ? "R9" : "R5";
    launch(m, nb, sz);
    for (int b = 0; b < nb; b++) begin
      xchg(8'hFF, 8'hFF, 1'b0, "R1");
      xchg(m ? 8'hFC : 8'hFE, 8'hFF, 1'b0, "R1");
      crc = 16'h0000;
      for (int i = 0; i < sz; i++) begin
        crc = crc_bits(crc, pat(b, i));
        xchg(pat(b, i), 8'hFF, 1'b1, "R2");
      end
      xchg(crc[15:8], 8'hFF, 1'b0, "R3");
      xchg(crc[7:0], 8'hFF, 1'b0, "R3");
      if (b == bad_blk && bad_tok == 8'hFF) begin
        for (int k = 0; k < 8; k++) xchg(8'hFF, 8'hFF, 1'b0, "R5");
        check_done(eerr, abort_tag);
        return;
      end
      for (int k = 0; k < rdel; k++) xchg(8'hFF, 8'hFF, 1'b0, "R4");
      if (b == bad_blk) begin
        xchg(8'hFF, bad_tok, 1'b0, "R5");
        check_done(eerr, abort_tag);
        return;
      end
      xchg(8'hFF, 8'hE5, 1'b0, "R4");
      busy_phase(bsy, "R6", tmo);
      if (tmo) begin
        check_done(eerr, "R7");
        return;
      end
    end
    if (m) begin
      xchg(8'hFF, 8'hFF, 1'b0, "R8");
      xchg(8'hFD, 8'hFF, 1'b0, "R8");
      busy_phase(sbsy, "R8", tmo);
      if (tmo) begin
        check_done(eerr, "R7");
        return;
      end
    end
    check_done(eerr, "R8");
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; multi = 1'b0; blk_count = '0; blk_size = '0;
    pl_data = 8'h00; pl_valid = 1'b0; bx_ack = 1'b0; bx_rx = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    nvec++;
    if (busy || done || bx_valid || pl_ready) begin
      nbad++;
      $display("FAIL R10: busy=%0b done=%0b valid=%0b ready=%0b expected all 0",
               busy, done, bx_valid, pl_ready);
    end
    for (int sz = 1; sz < 16; sz++) run(1'b0, 1, sz, sz % 8, -1, 8'h00, sz % 4, 0, E_OK);
    for (int m = 0; m < 2; m++)
      for (int nb = 1; nb <= 4; nb++)
        for (int sz = 1; sz <= 3; sz++)
          run(m[0], nb, sz, (nb + sz) % 8, -1, 8'h00, nb, sz, E_OK);
    run(1'b1, 7, 2, 3, -1, 8'h00, 2, 1, E_OK);
    for (int rd = 0; rd < 8; rd++) run(1'b0, 1, 2, rd, -1, 8'h00, 1, 0, E_OK);
    run(1'b0, 1, 2, 0, 0, 8'hFF, 1, 0, E_REJ);
    run(1'b0, 1, 2, 2, 0, 8'hEB, 1, 0, E_REJ);
    run(1'b0, 1, 3, 7, 0, 8'h0D, 1, 0, E_REJ);
    run(1'b1, 3, 2, 1, 1, 8'h0B, 1, 0, E_REJ);
    run(1'b1, 2, 1, 0, 1, 8'hFF, 1, 0, E_REJ);
    run(1'b0, 1, 2, 0, -1, 8'h00, 0, 0, E_OK);
    run(1'b0, 1, 2, 0, -1, 8'h00, LIM - 1, 0, E_OK);
    run(1'b0, 1, 2, 0, -1, 8'h00, LIM, 0, E_TMO);
    run(1'b1, 3, 1, 0, -1, 8'h00, LIM, 0, E_TMO);
    run(1'b1, 2, 1, 0, -1, 8'h00, 2, LIM - 1, E_OK);
    run(1'b1, 2, 1, 0, -1, 8'h00, 2, LIM, E_TMO);
    summary();
    $finish;
  end
endmodule